// File: doc/BRIEF.md
# Direct-Mapped Branch History Table

This block guesses whether a conditional branch will be taken. The fetch stage presents a branch address on the lookup port and gets a taken or not-taken guess back in the same cycle, with no register in the path. Once the branch resolves later in the pipeline, the real outcome and the branch address come back on the update port, and the entry they select is trained at the next clock edge.

The table is indexed by the word-address bits of the branch, taken just above the byte offset. It keeps no tags. Two branches whose index bits match therefore share one entry and one guess, and this aliasing is accepted.

A parameter selects the form of each entry:
- a single bit that holds the most recent outcome, or
- a two-bit saturating counter. With the counter, a single surprise outcome, such as the exit of a loop, does not reverse a strongly held guess.

Top module: `bht_predictor`

## Requirements
- R1: After reset, every entry predicts not-taken. In counter mode each counter holds 01 (weakly not-taken). In one-bit mode each bit holds 0.
- R2: The entry is selected by address bits [IDX_W+1:2]. Bits [1:0] and all bits above IDX_W+1 have no effect, so two addresses that differ only in those bits share one entry.
- R3: `lk_taken` is a combinational function of `lk_pc` and the table contents. It reflects a new `lk_pc` within the same cycle, without waiting for a clock edge.
- R4: In one-bit mode, an update stores `up_taken` in the addressed entry. Later lookups of that entry return exactly the last stored outcome.
- R5: In counter mode, a taken update increments the addressed counter and stops at 11. Increments never wrap to 00.
- R6: In counter mode, a not-taken update decrements the addressed counter and stops at 00. Decrements never wrap to 11.
- R7: In counter mode the prediction is the counter MSB. The codes 10 and 11 predict taken, and the codes 00 and 01 predict not-taken. Starting from 11, one not-taken update still predicts taken, and a second one predicts not-taken.
- R8: If a lookup and an update select the same entry in the same cycle, the lookup returns the value from before the update. The new value appears from the cycle after the clock edge.
- R9: An update changes only the entry it addresses. Lookups of every other index return the same prediction as before.
- R10: While `up_valid` is low, `up_pc` and `up_taken` have no effect on any entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the table is written on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | ADDR_W | Address of the branch being fetched |
| lk_taken | output | 1 | Prediction for `lk_pc`: 1 = taken, 0 = not-taken |
| up_valid | input | 1 | High when an update is presented this cycle |
| up_pc | input | ADDR_W | Address of the branch that resolved |
| up_taken | input | 1 | Resolved outcome: 1 = taken, 0 = not-taken |

## Verification
The checker assumes that `up_valid`, `up_pc` and `up_taken` are known whenever reset is released. It also assumes the configuration leaves at least one address bit above the index, so the ignored upper field exists. The stimulus meets both assumptions:
- It drives every input to a defined value from time zero.
- It changes inputs only on the falling clock edge, so each sampled value is settled at the rising edge.
- It uses the default 32-bit address with a 6-bit index, which leaves plenty of upper bits.

The properties about unchanged predictions compare lookups at the same index in consecutive cycles. For that reason the tests hold `lk_pc` steady across the cycles in which they observe an entry.

// File: rtl/bht_predictor.sv
module bht_predictor #(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 6,
  parameter bit TWO_BIT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_pc,
  output logic              lk_taken,
  input  logic              up_valid,
  input  logic [ADDR_W-1:0] up_pc,
  input  logic              up_taken
);

  localparam int DEPTH = 1 << IDX_W;
  localparam int CW    = TWO_BIT ? 2 : 1;
  localparam logic [CW-1:0] INIT = CW'(TWO_BIT ? 1 : 0);
  localparam logic [CW-1:0] TOP  = {CW{1'b1}};

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [CW-1:0]    tbl [DEPTH];
  logic [CW-1:0]    cur, nxt;

  assign lk_idx   = lk_pc[IDX_W+1:2];
  assign up_idx   = up_pc[IDX_W+1:2];
  assign lk_taken = tbl[lk_idx][CW-1];
  assign cur      = tbl[up_idx];

  logic unused_bits;
  assign unused_bits = ^{lk_pc[ADDR_W-1:IDX_W+2], lk_pc[1:0],
                         up_pc[ADDR_W-1:IDX_W+2], up_pc[1:0]};

  generate
    if (TWO_BIT) begin : g_ctr
      always_comb begin
        if (up_taken) nxt = (cur == TOP) ? cur : cur + CW'(1);
        else          nxt = (cur == '0)  ? cur : cur - CW'(1);
      end
    end else begin : g_bit
      logic unused_cur;
      assign unused_cur = ^cur;
      assign nxt = up_taken;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= INIT;
    end else if (up_valid) begin
      tbl[up_idx] <= nxt;
    end
  end

endmodule

// File: rtl/bht_predictor_chk.sv
module bht_predictor_chk #(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 6,
  parameter bit TWO_BIT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] lk_pc,
  input logic              lk_taken,
  input logic              up_valid,
  input logic [ADDR_W-1:0] up_pc,
  input logic              up_taken
);

  logic [IDX_W-1:0] li, ui;
  assign li = lk_pc[IDX_W+1:2];
  assign ui = up_pc[IDX_W+1:2];

  AST_RESET_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !lk_taken);  // R1

  AST_UNTOUCHED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_valid || ui != li) |=> ((li == $past(li)) -> $stable(lk_taken)));  // R9

  AST_TAKEN_KEEPS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_taken && ui == li && lk_taken) |=> ((li == $past(li)) -> lk_taken));  // R5

  AST_NT_KEEPS_NT: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !up_taken && ui == li && !lk_taken) |=> ((li == $past(li)) -> !lk_taken));  // R6

  generate
    if (!TWO_BIT) begin : g_one
      AST_LAST_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && ui == li) |=> ((li == $past(li)) -> (lk_taken == $past(up_taken))));  // R4
    end
  endgenerate

endmodule

bind bht_predictor bht_predictor_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TWO_BIT(TWO_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
  .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken));

// File: tb/bht_predictor_tb.sv
module bht_predictor_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        up_valid = 1'b0;
  logic [31:0] up_pc = '0;
  logic        up_taken = 1'b0;
  logic        p2, p1;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  bht_predictor #(.ADDR_W(32), .IDX_W(6), .TWO_BIT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(p2),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken));

  bht_predictor #(.ADDR_W(32), .IDX_W(6), .TWO_BIT(1'b0)) u_dut_1b (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(p1),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken));

  task automatic chk(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic upd(input logic [31:0] pc, input logic tk);
    @(negedge clk);
    up_valid = 1'b1; up_pc = pc; up_taken = tk;
    @(negedge clk);
    up_valid = 1'b0;
  endtask

  task automatic look(input logic [31:0] pc);
    lk_pc = pc;
    #1;
  endtask

  task automatic t_reset;
    for (int i = 0; i < 4; i++) begin
      look(32'h0000_1000 + 32'(i * 4));
      chk(p2, 1'b0, "R1 counter mode");
      chk(p1, 1'b0, "R1 one-bit mode");
    end
  endtask

  task automatic t_counter;
    upd(32'h1004, 1'b1); look(32'h1004); chk(p2, 1'b1, "R7 01->10 predicts taken");
    for (int i = 0; i < 5; i++) upd(32'h1004, 1'b1);
    look(32'h1004); chk(p2, 1'b1, "R5 saturated at 11");
    upd(32'h1004, 1'b0); look(32'h1004); chk(p2, 1'b1, "R7 11->10 still taken");
    upd(32'h1004, 1'b0); look(32'h1004); chk(p2, 1'b0, "R7 10->01 not taken");
    for (int i = 0; i < 5; i++) upd(32'h1004, 1'b0);
    look(32'h1004); chk(p2, 1'b0, "R6 saturated at 00");
    upd(32'h1004, 1'b1); look(32'h1004); chk(p2, 1'b0, "R6 00->01 not taken");
    upd(32'h1004, 1'b1); look(32'h1004); chk(p2, 1'b1, "R5 01->10 taken");
  endtask

  task automatic t_alias;
    upd(32'h2008, 1'b1); upd(32'h2008, 1'b1);
    look(32'h200B); chk(p2, 1'b1, "R2 low bits ignored");
    look(32'h2108); chk(p2, 1'b1, "R2 upper bits alias");
    look(32'hF000_2008); chk(p2, 1'b1, "R2 high bits alias");
    look(32'h2018); chk(p2, 1'b0, "R9 other index untouched");
    chk(p1, 1'b0, "R9 other index untouched one-bit");
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    lk_pc = 32'h300C; up_valid = 1'b1; up_pc = 32'h300C; up_taken = 1'b1;
    #1;
    chk(p2, 1'b0, "R8 pre-update value");
    chk(p1, 1'b0, "R8 pre-update value one-bit");
    @(negedge clk);
    up_valid = 1'b0;
    #1;
    chk(p2, 1'b1, "R8 new value after edge");
    look(32'h1004); chk(p2, 1'b1, "R3 combinational lookup");
    look(32'h5020); chk(p2, 1'b0, "R3 combinational lookup");
  endtask

  task automatic t_ignore;
    @(negedge clk);
    up_valid = 1'b0; up_pc = 32'h4010; up_taken = 1'b1;
    repeat (4) @(negedge clk);
    look(32'h4010);
    chk(p2, 1'b0, "R10 invalid update ignored");
    chk(p1, 1'b0, "R10 invalid update ignored one-bit");
  endtask

  task automatic t_one_bit;
    upd(32'h5014, 1'b1); look(32'h5014); chk(p1, 1'b1, "R4 last outcome taken");
    upd(32'h5014, 1'b0); look(32'h5014); chk(p1, 1'b0, "R4 last outcome not taken");
    upd(32'h5014, 1'b1); look(32'h5014); chk(p1, 1'b1, "R4 last outcome taken again");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_counter();
    t_alias();
    t_same_cycle();
    t_ignore();
    t_one_bit();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule